// File: doc/BRIEF.md
# Display Timing Tick Generator

This block turns a 5 MHz reference, given as a one-cycle enable inside a single synchronous clock domain, into the timing strobes that a display subsystem runs on. A divide-by-five stage yields a 1 MHz phase. Two halving stages follow it and yield 500 kHz and 250 kHz phases. The block also provides the complement of the 250 kHz phase for the intensity and display sequencers. A sample strobe goes low only in the short window where all three phases are high. That window falls once in every 250 kHz period.

Every divider moves only on a reference enable. A synchronous reset returns all divider state to zero, so the first sample-low window always lands a fixed number of reference ticks after reset. Each phase also has a single-cycle tick. The tick is high in the first clock cycle in which its phase is high, so downstream logic can use it directly as a count enable.

The 1 MHz phase cannot be exactly 50 % at five reference ticks per period. It is high for two of its five ticks. Because of this, the sample-low window lasts 2 of 20 reference ticks, which is the nearest whole-tick value to one eighth.

Top module: `disp_tick_gen`

## Requirements
- R1: While `rst` is high at a clock edge, all divider state is cleared, and this holds even when `refTick` is high in the same cycle. After reset, `phase1m`, `phase500k` and `phase250k` are 0, `phase250kN` and `sampleN` are 1, and all ticks are 0.
- R2: Let n be the number of reference enables since reset. Then `phase1m` is 1 exactly when n mod 5 is 3 or 4.
- R3: State advances only on a clock edge where `refTick` is 1. In cycles without `refTick`, every phase level holds and every tick is 0. This is true both when enables come on every cycle and when they are sparse.
- R4: Let s = floor(n / 5) mod 4. Then `phase500k` equals bit 0 of s and `phase250k` equals bit 1 of s.
- R5: `phase250kN` is always the complement of `phase250k`.
- R6: `sampleN` is 0 exactly when `phase1m`, `phase500k` and `phase250k` are all 1. This means n mod 20 is 18 or 19, so after reset the first low begins with the 18th enable and ends with the 20th.
- R7: `tick1m` is 1 for exactly one cycle, namely the first cycle in which `phase1m` is 1, and it is 0 in every other cycle.
- R8: `tick500k` and `tick250k` are 1 for exactly one cycle, namely the first cycle in which their own phase is 1.
- R9: No two tick outputs are ever 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock of the single synchronous domain |
| rst | input | 1 | Synchronous reset, active high |
| refTick | input | 1 | One-cycle 5 MHz reference enable |
| phase1m | output | 1 | 1 MHz phase level |
| phase500k | output | 1 | 500 kHz phase level |
| phase250k | output | 1 | 250 kHz phase level |
| phase250kN | output | 1 | Complement of the 250 kHz phase |
| sampleN | output | 1 | Sample strobe, low while all three phases are high |
| tick1m | output | 1 | One-cycle tick at the rise of the 1 MHz phase |
| tick500k | output | 1 | One-cycle tick at the rise of the 500 kHz phase |
| tick250k | output | 1 | One-cycle tick at the rise of the 250 kHz phase |

## Verification
Two events can land in the same clock cycle. The first pair is a reference enable and a synchronous reset: the bench runs a few enables and then raises `rst` and `refTick` together. It expects every output to be back in its reset state and the count of enables to start again from zero. The second pair is the end of a divide-by-five group and a slot advance: the 1 MHz phase falls in the same cycle that a slower phase rises or falls. Enables sent on every clock cycle put these boundaries back to back, and the bench checks each output against counts computed from the enable number alone.

// File: rtl/disp_tick_pkg.sv
package disp_tick_pkg;

  // Strobes from the reference divider to the slot datapath.
  typedef struct packed {
    logic refAdv;    // a reference enable was accepted this cycle
    logic slotWrap;  // divide-by-N group ends on this enable
    logic subRise;   // fast phase rises on this enable
  } ctlStrobe_t;

endpackage

// File: rtl/disp_tick_refdiv.sv
module disp_tick_refdiv
  import disp_tick_pkg::*;
#(
  parameter int REF_DIV   = 5,
  parameter int HIGH_FROM = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       refTick,
  output ctlStrobe_t strobes,
  output logic       subPhase
);

  localparam int CNT_W = (REF_DIV > 1) ? $clog2(REF_DIV) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(REF_DIV - 1);
  localparam logic [CNT_W-1:0] RISE_CNT = CNT_W'(HIGH_FROM - 1);
  localparam logic [CNT_W-1:0] HIGH_CNT = CNT_W'(HIGH_FROM);

  logic [CNT_W-1:0] divCnt;
  logic             atLast;
  logic             accept;

  assign atLast = (divCnt == LAST_CNT);
  assign accept = refTick & ~rst;

  always_ff @(posedge clk) begin
    if (rst) begin
      divCnt <= '0;
    end else if (refTick) begin
      divCnt <= atLast ? '0 : divCnt + 1'b1;
    end
  end

  always_comb begin
    strobes.refAdv   = accept;
    strobes.slotWrap = accept & atLast;
    strobes.subRise  = accept & (divCnt == RISE_CNT);
  end

  assign subPhase = (divCnt >= HIGH_CNT);

  // R2
  div_range_chk: assert property (@(posedge clk) disable iff (rst)
    divCnt <= LAST_CNT);

  // R2
  div_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.slotWrap |=> (divCnt == '0));

  // R3
  div_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !refTick |=> $stable(divCnt));

  // R1
  div_reset_chk: assert property (@(posedge clk)
    rst |=> (divCnt == '0));

endmodule

// File: rtl/disp_tick_slots.sv
module disp_tick_slots
  import disp_tick_pkg::*;
#(
  parameter int SLOT_BITS = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  ctlStrobe_t           strobes,
  input  logic                 subPhase,
  output logic [SLOT_BITS-1:0] slotPhase,
  output logic [SLOT_BITS-1:0] slotTick,
  output logic                 subTick,
  output logic                 sampleN,
  output logic                 lastPhaseN
);

  logic [SLOT_BITS-1:0] slotCnt;
  logic [SLOT_BITS-1:0] slotTickQ;
  logic                 subTickQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      slotCnt <= '0;
    end else if (strobes.slotWrap) begin
      slotCnt <= slotCnt + 1'b1;
    end
  end

  // Bit i rises when the slot count carries into it: bit i is 0 and all
  // lower bits are 1 as the group ends.
  for (genvar i = 0; i < SLOT_BITS; i++) begin : g_rise
    localparam logic [SLOT_BITS-1:0] LOW_MASK = SLOT_BITS'((1 << i) - 1);
    logic riseNow;
    assign riseNow = strobes.slotWrap & ~slotCnt[i] &
                     ((slotCnt & LOW_MASK) == LOW_MASK);
    always_ff @(posedge clk) begin
      if (rst) slotTickQ[i] <= 1'b0;
      else     slotTickQ[i] <= riseNow;
    end

    // R8
    slot_tick_chk: assert property (@(posedge clk) disable iff (rst)
      slotTickQ[i] |-> (slotCnt[i] && !$past(slotCnt[i])));
  end

  always_ff @(posedge clk) begin
    if (rst) subTickQ <= 1'b0;
    else     subTickQ <= strobes.subRise;
  end

  assign slotPhase  = slotCnt;
  assign slotTick   = slotTickQ;
  assign subTick    = subTickQ;
  assign sampleN    = ~(subPhase & (&slotCnt));
  assign lastPhaseN = ~slotCnt[SLOT_BITS-1];

  // R3
  slot_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !strobes.slotWrap |=> $stable(slotCnt));

  // R6
  sample_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(sampleN) |-> $past(strobes.subRise));

  // R7
  sub_tick_chk: assert property (@(posedge clk) disable iff (rst)
    subTickQ |-> (subPhase && !$past(subPhase)));

  // R9
  tick_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({subTickQ, slotTickQ}));

endmodule

// File: rtl/disp_tick_gen.sv
module disp_tick_gen
  import disp_tick_pkg::*;
#(
  parameter int REF_DIV   = 5,
  parameter int HIGH_FROM = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic refTick,
  output logic phase1m,
  output logic phase500k,
  output logic phase250k,
  output logic phase250kN,
  output logic sampleN,
  output logic tick1m,
  output logic tick500k,
  output logic tick250k
);

  localparam int SLOT_BITS = 2;

  ctlStrobe_t           strobes;
  logic                 subPhase;
  logic [SLOT_BITS-1:0] slotPhase;
  logic [SLOT_BITS-1:0] slotTick;
  logic                 subTick;
  logic                 sampleLow;
  logic                 lastN;

  disp_tick_refdiv #(
    .REF_DIV  (REF_DIV),
    .HIGH_FROM(HIGH_FROM)
  ) u_refdiv (
    .clk     (clk),
    .rst     (rst),
    .refTick (refTick),
    .strobes (strobes),
    .subPhase(subPhase)
  );

  disp_tick_slots #(
    .SLOT_BITS(SLOT_BITS)
  ) u_slots (
    .clk       (clk),
    .rst       (rst),
    .strobes   (strobes),
    .subPhase  (subPhase),
    .slotPhase (slotPhase),
    .slotTick  (slotTick),
    .subTick   (subTick),
    .sampleN   (sampleLow),
    .lastPhaseN(lastN)
  );

  assign phase1m    = subPhase;
  assign phase500k  = slotPhase[0];
  assign phase250k  = slotPhase[1];
  assign phase250kN = lastN;
  assign sampleN    = sampleLow;
  assign tick1m     = subTick;
  assign tick500k   = slotTick[0];
  assign tick250k   = slotTick[1];

endmodule

// File: tb/sim_disp_tick_gen.sv
`timescale 1ns/1ps
module sim_disp_tick_gen;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic refTick = 1'b0;
  logic phase1m, phase500k, phase250k, phase250kN, sampleN;
  logic tick1m, tick500k, tick250k;

  int nChecks = 0;
  int nErr = 0;
  int kRef = 0;
  bit done = 0;

  always #2 clk = ~clk;

  disp_tick_gen u0 (
    .clk       (clk),
    .rst       (rst),
    .refTick   (refTick),
    .phase1m   (phase1m),
    .phase500k (phase500k),
    .phase250k (phase250k),
    .phase250kN(phase250kN),
    .sampleN   (sampleN),
    .tick1m    (tick1m),
    .tick500k  (tick500k),
    .tick250k  (tick250k)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s %s actual=%0b expected=%0b (enable %0d)", req, what, act, exp, kRef);
    end
  endtask

  // Compare every output with the values derived from kRef.
  task automatic checkAll(input bit hadRef);
    int c = kRef % 5;
    int s = (kRef / 5) % 4;
    logic e1m = (c >= 3);
    logic e500 = s[0];
    logic e250 = s[1];
    chk("R2", "phase1m", phase1m, e1m);
    chk("R4", "phase500k", phase500k, e500);
    chk("R4", "phase250k", phase250k, e250);
    chk("R5", "phase250kN", phase250kN, ~e250);
    chk("R6", "sampleN", sampleN, ~(e1m & e500 & e250));
    chk(hadRef ? "R7" : "R3", "tick1m", tick1m, hadRef && c == 3);
    chk(hadRef ? "R8" : "R3", "tick500k", tick500k, hadRef && c == 0 && s % 2 == 1);
    chk(hadRef ? "R8" : "R3", "tick250k", tick250k, hadRef && c == 0 && s == 2);
    chk("R9", "tick exclusivity", ($countones({tick1m, tick500k, tick250k}) <= 1), 1'b1);
  endtask

  task automatic stepCycle(input bit withRef);
    refTick = withRef;
    @(posedge clk); #1;
    if (withRef) kRef++;
    refTick = 1'b0;
    checkAll(withRef);
  endtask

  task automatic doReset(input bit withRef);
    rst = 1'b1;
    refTick = withRef;
    @(posedge clk); #1;
    rst = 1'b0;
    refTick = 1'b0;
    kRef = 0;
  endtask

  task automatic testReset();
    doReset(1'b0);
    doReset(1'b0);
    chk("R1", "phase1m", phase1m, 1'b0);
    chk("R1", "phase500k", phase500k, 1'b0);
    chk("R1", "phase250k", phase250k, 1'b0);
    chk("R1", "phase250kN", phase250kN, 1'b1);
    chk("R1", "sampleN", sampleN, 1'b1);
    chk("R1", "ticks", tick1m | tick500k | tick250k, 1'b0);
  endtask

  task automatic testSparse();
    doReset(1'b0);
    for (int i = 0; i < 45; i++) begin
      stepCycle(1'b1);
      stepCycle(1'b0);
      stepCycle(1'b0);
    end
  endtask

  task automatic testDense();
    doReset(1'b0);
    for (int i = 0; i < 45; i++) stepCycle(1'b1);
  endtask

  task automatic testIdleHold();
    doReset(1'b0);
    for (int i = 0; i < 18; i++) stepCycle(1'b1);
    // R3: sample-low window reached; long gap must not move anything
    for (int i = 0; i < 12; i++) stepCycle(1'b0);
    chk("R3", "sampleN held low", sampleN, 1'b0);
  endtask

  task automatic testSampleWindow();
    int firstLow = -1;
    int firstHigh = -1;
    doReset(1'b0);
    for (int i = 0; i < 40; i++) begin
      stepCycle(1'b1);
      if (firstLow < 0 && sampleN == 1'b0) firstLow = kRef;
      if (firstLow >= 0 && firstHigh < 0 && sampleN == 1'b1) firstHigh = kRef;
    end
    nChecks++;
    if (firstLow != 18) begin
      nErr++;
      $display("FAIL R6 first sample low at enable actual=%0d expected=18", firstLow);
    end
    nChecks++;
    if (firstHigh != 20) begin
      nErr++;
      $display("FAIL R6 sample high again at enable actual=%0d expected=20", firstHigh);
    end
  endtask

  task automatic testResetWithRef();
    doReset(1'b0);
    for (int i = 0; i < 13; i++) stepCycle(1'b1);
    doReset(1'b1);  // R1: reset wins over a coincident enable
    checkAll(1'b0);
    chk("R1", "phase500k after coincident reset", phase500k, 1'b0);
    for (int i = 0; i < 6; i++) stepCycle(1'b1);
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nErr++;
      nChecks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finishRun();
    end
  end

  initial begin
    #1;
    testReset();
    testSparse();
    testDense();
    testIdleHold();
    testSampleWindow();
    testResetWithRef();
    done = 1;
    finishRun();
  end

endmodule